// File: doc/BRIEF.md
# Load-Use Stall Interlock

This block is the hazard-control unit for an in-order pipeline with four stages: fetch, execute, memory access and writeback. The pipeline has no operand bypass network. An arithmetic result is already usable when the next instruction reaches execute, so only one case needs help. When a load is in execute, its data is produced one stage too late for the instruction right behind it. The unit compares the load's destination register with the source register fields of the instruction sitting in fetch. On a match it raises a stall, so that the program counter and the fetch register hold for one cycle, and it puts a no-operation bubble into execute.

The unit also carries the control bits of every instruction (valid, load, register write, memory write, destination register) through execute, memory and writeback. An injected bubble therefore drives no write enable as it passes down the pipe. The unit produces the register-file write enable and destination at writeback, and the memory write enable at the memory stage. The register file, ALU, memory and branch logic are outside the block.

Top module: `lus_interlock`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `stall_o`, `ex_bubble_o`, `mem_we_o`, `wb_retire_o` and `wb_we_o` are all low.
- R2: `stall_o` is high in the same cycle (combinationally) when the valid fetch-stage instruction reads the destination of a load that is currently in execute. rs1 counts when `f_rs1_used` is 1. rs2 counts when `f_imm` is 0.
- R3: A stall lasts exactly one cycle. In the next cycle, with the same fetch inputs held, `stall_o` is low.
- R4: With register 0 hardwired (default), a load whose destination is 0 never causes a stall, and `wb_we_o` is never high with `wb_rd_o` equal to 0.
- R5: rs2 does not cause a stall when `f_imm` is 1. rs1 does not cause a stall when `f_rs1_used` is 0.
- R6: There is no stall when execute holds no load, when the fetched instruction is independent, or when the dependent instruction comes two or more slots after the load.
- R7: In the cycle after a stall, `ex_bubble_o` is high. The bubble keeps `mem_we_o` low two cycles after the stall, and keeps `wb_retire_o` and `wb_we_o` low three cycles after the stall.
- R8: An instruction that leaves fetch on a clock edge shows at writeback after the third rising edge, counting that edge as the first. At writeback, `wb_retire_o` is 1, `wb_rd_o` is its destination, and `wb_we_o` equals its register-write flag ANDed with a nonzero destination.
- R9: A valid instruction with `f_mem_we` set drives `mem_we_o` high for exactly the one cycle it spends in the memory stage.
- R10: A stream of N instructions that contains B adjacent load-use pairs has its last retirement visible after N+B+2 rising edges, counted from the first edge at which the first instruction is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| f_valid | input | 1 | Fetch-stage instruction is valid |
| f_load | input | 1 | Fetch-stage instruction is a load |
| f_rd | input | REG_W | Destination register |
| f_reg_we | input | 1 | Instruction writes the register file |
| f_mem_we | input | 1 | Instruction writes memory |
| f_rs1 | input | REG_W | First source register |
| f_rs1_used | input | 1 | First source is read |
| f_rs2 | input | REG_W | Second source register |
| f_imm | input | 1 | Second operand is an immediate (rs2 not read) |
| stall_o | output | 1 | Hold PC and fetch register this cycle |
| ex_bubble_o | output | 1 | Execute holds an injected bubble |
| mem_we_o | output | 1 | Memory write enable, memory stage |
| wb_retire_o | output | 1 | A valid instruction is in writeback |
| wb_we_o | output | 1 | Register-file write enable |
| wb_rd_o | output | REG_W | Register-file write address |

## Verification
If the execute-stage state is wrong, for example a bubble left marked valid or a destination field corrupted, the error shows on `stall_o` in the very next cycle. The next fetched instruction either stalls when it should not or passes when it should not. The same error reaches `mem_we_o` one cycle later and `wb_we_o`/`wb_rd_o` two cycles later. A lost or duplicated bubble also changes the total cycle count of a scripted stream. The bench sweeps every combination of load destination, both source fields and both operand-use flags in an 8-register configuration. It also follows a mixed stream cycle by cycle against a stage model.

// File: rtl/lus_pkg.sv
package lus_pkg;
   localparam int LUS_MAX_REG_W   = 8;
   localparam int LUS_BACK_STAGES = 3;   // execute, memory, writeback

   typedef struct packed {
      logic                     valid;
      logic                     load;
      logic                     reg_we;
      logic                     mem_we;
      logic [LUS_MAX_REG_W-1:0] rd;
   } lus_ctl_t;

   localparam lus_ctl_t LUS_BUBBLE = '0;
endpackage

// File: rtl/lus_src_match.sv
module lus_src_match #(
   parameter int REG_W              = 5,
   parameter int NUM_SRC            = 2,
   parameter bit ZERO_REG_HARDWIRED = 1'b1
) (
   input  logic [NUM_SRC-1:0][REG_W-1:0] src_idx,
   input  logic [NUM_SRC-1:0]            src_en,
   input  logic [REG_W-1:0]              ld_rd,
   input  logic                          ld_active,
   output logic                          hit
);
   logic [NUM_SRC-1:0] match;
   logic               rd_live;

   if (NUM_SRC < 1) begin : g_bad_src
      $error("lus_src_match: NUM_SRC must be at least 1");
   end

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      assign match[g] = src_en[g] && (src_idx[g] == ld_rd);
   end

   if (ZERO_REG_HARDWIRED) begin : g_zero_hw
      assign rd_live = |ld_rd;
   end else begin : g_zero_gp
      assign rd_live = 1'b1;
   end

   assign hit = ld_active && rd_live && (|match);
endmodule

// File: rtl/lus_ctl_stage.sv
module lus_ctl_stage
   import lus_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  lus_ctl_t d,
   input  logic     kill,
   output lus_ctl_t q
);
   always_ff @(posedge clk) begin
      if (!rst_n)    q <= LUS_BUBBLE;
      else if (kill) q <= LUS_BUBBLE;
      else           q <= d;
   end
endmodule

// File: rtl/lus_interlock.sv
module lus_interlock
   import lus_pkg::*;
#(
   parameter int REG_W              = 5,
   parameter bit ZERO_REG_HARDWIRED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             f_valid,
   input  logic             f_load,
   input  logic [REG_W-1:0] f_rd,
   input  logic             f_reg_we,
   input  logic             f_mem_we,
   input  logic [REG_W-1:0] f_rs1,
   input  logic             f_rs1_used,
   input  logic [REG_W-1:0] f_rs2,
   input  logic             f_imm,
   output logic             stall_o,
   output logic             ex_bubble_o,
   output logic             mem_we_o,
   output logic             wb_retire_o,
   output logic             wb_we_o,
   output logic [REG_W-1:0] wb_rd_o
);
   localparam int NSRC   = 2;
   localparam int ST_EX  = 0;
   localparam int ST_MEM = 1;
   localparam int ST_WB  = LUS_BACK_STAGES - 1;

   if (REG_W < 1 || REG_W > LUS_MAX_REG_W) begin : g_bad_w
      $error("lus_interlock: REG_W out of range");
   end

   lus_ctl_t   fe_ctl;
   lus_ctl_t   st_d [LUS_BACK_STAGES];
   lus_ctl_t   st_q [LUS_BACK_STAGES];
   logic       st_kill [LUS_BACK_STAGES];
   logic [REG_W-1:0] ex_rd;
   logic       hazard;
   logic       bubble_q;
   logic [NSRC-1:0][REG_W-1:0] srcs;
   logic [NSRC-1:0]            src_en;

   always_comb begin
      fe_ctl        = LUS_BUBBLE;
      fe_ctl.valid  = f_valid;
      fe_ctl.load   = f_valid && f_load;
      fe_ctl.reg_we = f_valid && f_reg_we;
      fe_ctl.mem_we = f_valid && f_mem_we;
      fe_ctl.rd     = LUS_MAX_REG_W'(f_rd);
   end

   assign ex_rd  = st_q[ST_EX].rd[REG_W-1:0];
   assign srcs   = {f_rs2, f_rs1};
   assign src_en = {!f_imm, f_rs1_used};

   lus_src_match #(
      .REG_W              (REG_W),
      .NUM_SRC            (NSRC),
      .ZERO_REG_HARDWIRED (ZERO_REG_HARDWIRED)
   ) u_match (
      .src_idx   (srcs),
      .src_en    (src_en),
      .ld_rd     (ex_rd),
      .ld_active (f_valid && st_q[ST_EX].valid && st_q[ST_EX].load),
      .hit       (hazard)
   );

   for (genvar g = 0; g < LUS_BACK_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_head
         assign st_d[g]    = fe_ctl;
         assign st_kill[g] = hazard;
      end else begin : g_body
         assign st_d[g]    = st_q[g-1];
         assign st_kill[g] = 1'b0;
      end
      lus_ctl_stage u_stage (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (st_d[g]),
         .kill  (st_kill[g]),
         .q     (st_q[g])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) bubble_q <= 1'b0;
      else        bubble_q <= hazard;
   end

   assign stall_o     = hazard;
   assign ex_bubble_o = bubble_q;
   assign mem_we_o    = st_q[ST_MEM].valid && st_q[ST_MEM].mem_we;
   assign wb_retire_o = st_q[ST_WB].valid;
   assign wb_rd_o     = st_q[ST_WB].rd[REG_W-1:0];

   if (ZERO_REG_HARDWIRED) begin : g_wb_zero
      assign wb_we_o = st_q[ST_WB].valid && st_q[ST_WB].reg_we && (|wb_rd_o);
      AST_NO_R0_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
         wb_we_o |-> (wb_rd_o != '0)); // R4
   end else begin : g_wb_plain
      assign wb_we_o = st_q[ST_WB].valid && st_q[ST_WB].reg_we;
   end

   logic spare_unused;
   assign spare_unused = ^{st_q[ST_WB].load, st_q[ST_WB].mem_we, st_q[ST_WB].rd};

   // Checks on the interlock and the bubble as it drains
   AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      stall_o |=> !stall_o); // R3
   AST_STALL_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      stall_o |-> $past(f_valid && f_load && !stall_o)); // R6
   AST_BUBBLE_IN_EX: assert property (@(posedge clk) disable iff (!rst_n)
      stall_o |=> ex_bubble_o); // R7
   AST_BUBBLE_NO_MEM_WE: assert property (@(posedge clk) disable iff (!rst_n)
      stall_o |-> ##2 !mem_we_o); // R7
   AST_BUBBLE_NO_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
      stall_o |-> ##3 (!wb_retire_o && !wb_we_o)); // R7
   AST_R0_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (ZERO_REG_HARDWIRED && ex_rd == '0) |-> !stall_o); // R4
   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> (!mem_we_o && !wb_retire_o && !ex_bubble_o)); // R1
endmodule

// File: tb/tb_lus_interlock.sv
`timescale 1ns/1ps
module tb_lus_interlock;
   localparam int RW = 3;
   localparam int NPROG = 13;

   typedef struct packed {
      logic          valid;
      logic          load;
      logic [RW-1:0] rd;
      logic          reg_we;
      logic          mem_we;
      logic [RW-1:0] rs1;
      logic          use1;
      logic [RW-1:0] rs2;
      logic          imm;
   } ins_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   ins_t cur = '0;
   logic stall_o, ex_bubble_o, mem_we_o, wb_retire_o, wb_we_o;
   logic [RW-1:0] wb_rd_o;
   int nchk = 0;
   int nerr = 0;

   always #10 clk = ~clk;

   lus_interlock #(.REG_W(RW), .ZERO_REG_HARDWIRED(1'b1)) dut (
      .clk(clk), .rst_n(rst_n),
      .f_valid(cur.valid), .f_load(cur.load), .f_rd(cur.rd),
      .f_reg_we(cur.reg_we), .f_mem_we(cur.mem_we),
      .f_rs1(cur.rs1), .f_rs1_used(cur.use1), .f_rs2(cur.rs2), .f_imm(cur.imm),
      .stall_o(stall_o), .ex_bubble_o(ex_bubble_o), .mem_we_o(mem_we_o),
      .wb_retire_o(wb_retire_o), .wb_we_o(wb_we_o), .wb_rd_o(wb_rd_o)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic ins_t mk(input bit ld, input int rd, input bit rwe, input bit mwe,
                               input int r1, input bit u1, input int r2, input bit im);
      ins_t t;
      t.valid = 1'b1; t.load = ld; t.rd = RW'(rd); t.reg_we = rwe; t.mem_we = mwe;
      t.rs1 = RW'(r1); t.use1 = u1; t.rs2 = RW'(r2); t.imm = im;
      return t;
   endfunction

   // expected hazard from the requirements (R2, R4, R5, R6)
   function automatic bit exp_hz(input ins_t ex, input ins_t f);
      return ex.valid && ex.load && (ex.rd != 0) && f.valid &&
             ((f.use1 && f.rs1 == ex.rd) || (!f.imm && f.rs2 == ex.rd));
   endfunction

   function automatic ins_t prog(input int i);
      case (i)
         0:  return mk(1, 1, 1, 0, 2, 1, 0, 1); // ld r1
         1:  return mk(0, 3, 1, 0, 1, 1, 4, 0); // uses r1 -> stall
         2:  return mk(1, 5, 1, 0, 3, 1, 0, 1); // ld r5
         3:  return mk(0, 6, 1, 0, 2, 1, 7, 0); // independent
         4:  return mk(0, 7, 1, 0, 5, 1, 1, 0); // r5 two slots later
         5:  return mk(1, 0, 1, 0, 2, 1, 0, 1); // ld r0
         6:  return mk(0, 1, 1, 0, 0, 1, 0, 0); // reads r0, no stall
         7:  return mk(1, 2, 1, 0, 1, 1, 0, 1); // ld r2
         8:  return mk(0, 0, 0, 1, 3, 1, 2, 0); // store reads r2 via rs2 -> stall
         9:  return mk(1, 4, 1, 0, 6, 1, 0, 1); // ld r4
         10: return mk(0, 5, 1, 0, 6, 1, 4, 1); // rs2=r4 but immediate
         11: return mk(1, 6, 1, 0, 1, 1, 0, 1); // ld r6
         default: return mk(0, 1, 1, 0, 2, 1, 6, 0); // rs2 reads r6 -> stall
      endcase
   endfunction

   task automatic run_all();
      ins_t d1, d2, d3, f;
      bit b1, st;
      int pc, edges, retired, nbub;
      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1", "stall in reset", int'(stall_o), 0);
      chk("R1", "bubble in reset", int'(ex_bubble_o), 0);
      chk("R1", "mem_we in reset", int'(mem_we_o), 0);
      chk("R1", "retire in reset", int'(wb_retire_o), 0);
      chk("R1", "wb_we in reset", int'(wb_we_o), 0);
      rst_n = 1'b1;
      @(posedge clk); #1;
      @(negedge clk);
      chk("R1", "outputs after reset", int'({stall_o, ex_bubble_o, mem_we_o, wb_retire_o, wb_we_o}), 0);

      // Exhaustive pair sweep: load then consumer (R2..R7)
      for (int lr = 0; lr < 8; lr++)
         for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++)
               for (int m = 0; m < 4; m++) begin
                  ins_t ld, cs;
                  bit e;
                  ld = mk(1, lr, 1, 0, 0, 0, 0, 1);
                  cs = mk(0, 7, 1, 0, a, m[0], b, m[1]);
                  @(posedge clk); #1; cur = ld;
                  @(negedge clk);
                  chk("R6", "no stall without load in execute", int'(stall_o), 0);
                  @(posedge clk); #1; cur = cs;
                  e = exp_hz(ld, cs);
                  @(negedge clk);
                  if (lr == 0) chk("R4", "load to r0 stall", int'(stall_o), 0);
                  else if (!e) chk("R5_R6", "no-dependency stall", int'(stall_o), 0);
                  else         chk("R2", "load-use stall", int'(stall_o), 1);
                  if (stall_o) begin
                     @(posedge clk); #1;
                     @(negedge clk);
                     chk("R3", "stall released", int'(stall_o), 0);
                     chk("R7", "bubble in execute", int'(ex_bubble_o), 1);
                  end
               end
      @(posedge clk); #1; cur = '0;
      repeat (4) @(posedge clk); #1;

      // Scripted stream against a stage model (R7..R10)
      d1 = '0; d2 = '0; d3 = '0; b1 = 1'b0;
      pc = 0; edges = 0; retired = 0; nbub = 0;
      while (retired < NPROG && edges < 100) begin
         f = (pc < NPROG) ? prog(pc) : ins_t'('0);
         cur = f;
         st = exp_hz(d1, f);
         @(negedge clk);
         chk("R2", "stream stall", int'(stall_o), int'(st));
         chk("R7", "stream bubble flag", int'(ex_bubble_o), int'(b1));
         chk("R9", "memory write enable", int'(mem_we_o), int'(d2.valid && d2.mem_we));
         chk("R8", "retire", int'(wb_retire_o), int'(d3.valid));
         if (d3.valid) begin
            chk("R8", "write address", int'(wb_rd_o), int'(d3.rd));
            chk("R8_R4", "write enable", int'(wb_we_o), int'(d3.reg_we && d3.rd != 0));
         end else begin
            chk("R7", "no write from bubble", int'(wb_we_o), 0);
         end
         if (wb_retire_o) retired++;
         if (retired >= NPROG) break;
         @(posedge clk);
         edges++;
         d3 = d2; d2 = d1;
         d1 = st ? ins_t'('0) : f;
         b1 = st;
         if (st) nbub++;
         else if (pc < NPROG) pc++;
         #1;
      end
      chk("R10", "bubbles in stream", nbub, 3);
      chk("R10", "edges to last retirement", edges, NPROG + 3 + 2);
      cur = '0;
   endtask

   initial begin
      bit timed_out;
      timed_out = 1'b0;
      fork
         run_all();
         begin
            repeat (150000) @(posedge clk);
            timed_out = 1'b1;
         end
      join_any
      disable fork;
      if (timed_out) begin
         nchk++; nerr++;
         $display("FAIL watchdog: actual=1 expected=0");
      end
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule